// File: doc/BRIEF.md
# Fill-Until-Full DMA Write Channel

This block is one bus-master channel that keeps a local staging FIFO topped up with 32-bit words fetched from system memory. Software programs a first and a last dword address and a block length, then sets a go bit while an access-mode bit selects the DMA mode. The channel requests the bus whenever its FIFO has room and keeps requesting until the FIFO is full. It presents the current dword address with the request, stores each word the bus master hands over, and pulses an interrupt each time a block of the programmed size has been moved. A local consumer, typically a DRAM controller, drains the FIFO.

When the word at the last address has been taken, the channel clears its own go bit and stops with the pointer parked on that address. It does not wrap. The control register also holds two static DRAM configuration fields, the memory organisation code and the row/column multiplexer delay code. Both are driven straight out to the DRAM controller.

Top module: `dmaw_fill_channel`

## Requirements
- R1: After synchronous reset, `bm_req` and `blk_irq` are 0, `fifo_empty` is 1, `dram_type` is 00, `mux_delay` is 01, and reading the control register returns 0x0010_0003.
- R2: Register index 0 holds the first dword address and index 1 holds the last dword address. Each stores write bits 31:2 and reads back with bits 1:0 as 00. Index 2 is the control register, with organisation in 23:22, mux delay in 21:20, access mode in 17, go in 16 and block length in 15:2. Its bits 1:0 read as 11 and its other bits read as 0. Index 3 reads as 0. `reg_rdata` shows the selected register one cycle after `reg_addr` is applied.
- R3: `bm_req` is high exactly while go=1, mode=1 and the FIFO holds fewer than FIFO_DEPTH words. It follows changes of that state in the cycle after the edge that caused them.
- R4: With mode=0, go=1 raises no request, and `bm_ack` moves no data and no pointer.
- R5: A control write that changes go from 0 to 1 loads the pointer with the first address and restarts block counting. `bm_addr` always shows {pointer, 00}.
- R6: A cycle with `bm_ack` and `bm_req` both high stores `bm_data` in the FIFO and advances the pointer by one dword. `bm_ack` while `bm_req` is low changes nothing.
- R7: `blk_irq` is a one-cycle pulse in the cycle after each (length field + 1)-th accepted word of a block.
- R8: Accepting the word at the last address clears go. `bm_req` falls in the next cycle and the pointer stays on the last address. A control write in the same cycle takes precedence.
- R9: The FIFO returns words in arrival order. `fifo_rd_en` with data present puts the oldest word on `fifo_rd_data` in the next cycle. A read while `fifo_empty` is 1 is ignored.
- R10: `dram_type` and `mux_delay` follow the control register's organisation and delay fields.
- R11: A software write that clears go drops `bm_req` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 first, 1 last, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the indexed register |
| bm_req | output | 1 | Transfer request to the bus master |
| bm_addr | output | ADDR_W | Byte address of the next word to fetch |
| bm_ack | input | 1 | Bus master delivers a word this cycle |
| bm_data | input | DATA_W | Word delivered by the bus master |
| fifo_rd_en | input | 1 | Consumer pops one word |
| fifo_rd_data | output | DATA_W | Popped word, valid the cycle after the pop |
| fifo_empty | output | 1 | FIFO holds no words |
| blk_irq | output | 1 | One-cycle block-complete pulse |
| dram_type | output | 2 | DRAM organisation code |
| mux_delay | output | 2 | Row/column mux delay code |

## Verification
The bench targets three corner cases. The first is a FIFO that runs full while the bus master keeps acknowledging; a design that admitted that word would lose or overwrite data. The second is acceptance of the final address. A design that wrapped, or forgot to clear go, would keep `bm_req` high and move `bm_addr` back to the first address. The third is a go bit written while mode is 0, or written to 0 in the middle of a run. Getting that wrong shows up as a request that should not exist, or as a restart that resumes at the old pointer instead of the first address. Block lengths of one word and of four words exercise back-to-back interrupts and spaced interrupts, so an off-by-one in the length field moves every pulse.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

  localparam int unsigned BLEN_W = 14;

  localparam logic [1:0] IDX_FIRST = 2'd0;
  localparam logic [1:0] IDX_LAST  = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;

  localparam int unsigned B_TYPE  = 22;
  localparam int unsigned B_DLY   = 20;
  localparam int unsigned B_MODE  = 17;
  localparam int unsigned B_GO    = 16;
  localparam int unsigned B_BLEN  = 2;

  typedef struct packed {
    logic [1:0]        dram_org;
    logic [1:0]        mux_dly;
    logic              mode2;
    logic              go;
    logic [BLEN_W-1:0] blen;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{dram_org: 2'b00, mux_dly: 2'b01,
                                 mode2: 1'b0, go: 1'b0, blen: '0};

endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned AW    = ADDR_W - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  input  logic          hw_clr_go,
  output logic [31:0]   rdata,
  output logic [AW-1:0] first_dw,
  output logic [AW-1:0] last_dw,
  output ctrl_t         ctrl,
  output logic          go_set
);

  logic        ctrl_wr;
  logic [31:0] rd_mux;

  assign ctrl_wr = we && (addr == IDX_CTRL);
  assign go_set  = ctrl_wr && wdata[B_GO] && !ctrl.go;

  always_comb begin
    case (addr)
      IDX_FIRST: rd_mux = {first_dw, 2'b00};
      IDX_LAST:  rd_mux = {last_dw, 2'b00};
      IDX_CTRL:  rd_mux = {8'h00, ctrl.dram_org, ctrl.mux_dly, 2'b00,
                           ctrl.mode2, ctrl.go, ctrl.blen, 2'b11};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_dw <= '0;
      last_dw  <= '0;
      ctrl     <= CTRL_RST;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (hw_clr_go) ctrl.go <= 1'b0;
      if (we) begin
        case (addr)
          IDX_FIRST: first_dw <= wdata[31:2];
          IDX_LAST:  last_dw  <= wdata[31:2];
          IDX_CTRL: begin
            ctrl.dram_org <= wdata[B_TYPE+1:B_TYPE];
            ctrl.mux_dly  <= wdata[B_DLY+1:B_DLY];
            ctrl.mode2    <= wdata[B_MODE];
            ctrl.go       <= wdata[B_GO];
            ctrl.blen     <= wdata[B_BLEN+BLEN_W-1:B_BLEN];
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a hardware stop is honoured unless software rewrites control
  assert_hw_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (hw_clr_go && !ctrl_wr) |=> !ctrl.go);

endmodule

// File: rtl/dmaw_fifo.sv
module dmaw_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R6: the channel never offers a word to a full FIFO
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R9: popping an empty FIFO with no push leaves it empty
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> empty);

endmodule

// File: rtl/dmaw_engine.sv
module dmaw_engine #(
  parameter int unsigned AW     = 30,
  parameter int unsigned BLEN_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              go_set,
  input  logic [AW-1:0]     first_dw,
  input  logic [AW-1:0]     last_dw,
  input  logic [BLEN_W-1:0] blen,
  input  logic              ack,
  input  logic              full,
  output logic              req,
  output logic              acc,
  output logic              hw_clr_go,
  output logic [AW-1:0]     ptr,
  output logic              irq
);

  logic [BLEN_W-1:0] blk;
  logic              at_end, blk_done;

  assign req       = run && !full;
  assign acc       = ack && req;
  assign at_end    = (ptr == last_dw);
  assign blk_done  = (blk == blen);
  assign hw_clr_go = acc && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      blk <= '0;
      irq <= 1'b0;
    end else begin
      irq <= acc && blk_done;
      if (go_set) begin
        ptr <= first_dw;
        blk <= '0;
      end else if (acc) begin
        if (!at_end) ptr <= ptr + 1'b1;
        blk <= blk_done ? '0 : blk + 1'b1;
      end
    end
  end

  // R6: each accepted word mid-buffer steps the pointer by one dword
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && !at_end && !go_set) |=> (ptr == $past(ptr) + 1'b1));

  // R7: an interrupt pulse always follows an accepted word
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(acc));

  // R8: the pointer never moves past the last address
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && at_end && !go_set) |=> (ptr == $past(ptr)));

endmodule

// File: rtl/dmaw_fill_channel.sv
module dmaw_fill_channel
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bm_req,
  output logic [ADDR_W-1:0] bm_addr,
  input  logic              bm_ack,
  input  logic [DATA_W-1:0] bm_data,
  input  logic              fifo_rd_en,
  output logic [DATA_W-1:0] fifo_rd_data,
  output logic              fifo_empty,
  output logic              blk_irq,
  output logic [1:0]        dram_type,
  output logic [1:0]        mux_delay
);

  localparam int unsigned AW = ADDR_W - 2;

  ctrl_t          ctrl;
  logic [AW-1:0]  first_dw, last_dw, ptr;
  logic           go_set, hw_clr_go, run, acc, full;

  dmaw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .hw_clr_go (hw_clr_go),
    .rdata     (reg_rdata),
    .first_dw  (first_dw),
    .last_dw   (last_dw),
    .ctrl      (ctrl),
    .go_set    (go_set)
  );

  assign run = ctrl.go && ctrl.mode2;

  dmaw_engine #(.AW(AW), .BLEN_W(BLEN_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .go_set    (go_set),
    .first_dw  (first_dw),
    .last_dw   (last_dw),
    .blen      (ctrl.blen),
    .ack       (bm_ack),
    .full      (full),
    .req       (bm_req),
    .acc       (acc),
    .hw_clr_go (hw_clr_go),
    .ptr       (ptr),
    .irq       (blk_irq)
  );

  dmaw_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc),
    .wr_data (bm_data),
    .rd_en   (fifo_rd_en),
    .rd_data (fifo_rd_data),
    .full    (full),
    .empty   (fifo_empty)
  );

  assign bm_addr   = {ptr, 2'b00};
  assign dram_type = ctrl.dram_org;
  assign mux_delay = ctrl.mux_dly;

  // R4: no request unless both go and DMA mode are set
  assert_req_gate_R4: assert property (@(posedge clk) disable iff (rst)
    bm_req |-> (ctrl.mode2 && ctrl.go));

  // R3: a full FIFO never sees a request
  assert_req_full_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> !bm_req);

endmodule

// File: tb/dmaw_fill_channel_tb.sv
module dmaw_fill_channel_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bm_req;
  logic [31:0] bm_addr;
  logic        bm_ack = 1'b0;
  logic [31:0] bm_data = '0;
  logic        fifo_rd_en = 1'b0;
  logic [31:0] fifo_rd_data;
  logic        fifo_empty;
  logic        blk_irq;
  logic [1:0]  dram_type, mux_delay;

  always #2 clk = ~clk;

  dmaw_fill_channel #(.ADDR_W(32), .DATA_W(32), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bm_req(bm_req),
    .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_data(bm_data),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
    .fifo_empty(fifo_empty), .blk_irq(blk_irq), .dram_type(dram_type),
    .mux_delay(mux_delay)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int drv_mode = 0;
  logic [15:0] lf = 16'hACE1;

  // reference model state
  logic [29:0] m_sa, m_ea, m_ptr;
  logic [1:0]  m_type, m_dly;
  logic        m_mode, m_go, m_irq, m_have_rd;
  logic [13:0] m_blen, m_blk;
  logic [31:0] m_rdata, m_rd;
  logic [31:0] q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {m_sa, 2'b00};
      2'd1: return {m_ea, 2'b00};
      2'd2: return {8'h00, m_type, m_dly, 2'b00, m_mode, m_go, m_blen, 2'b11};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_req();
    return m_go && m_mode && (q.size() < DEPTH);
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_sa = '0; m_ea = '0; m_ptr = '0; m_type = 2'b00; m_dly = 2'b01;
      m_mode = 0; m_go = 0; m_blen = '0; m_blk = '0; m_irq = 0;
      m_rdata = '0; m_have_rd = 0; m_rd = '0; q.delete();
    end else begin
      logic accepted, old_go;
      accepted = bm_ack && m_req();
      old_go   = m_go;
      m_rdata  = m_read(reg_addr);
      m_irq    = accepted && (m_blk == m_blen);
      if (fifo_rd_en && q.size() > 0) begin
        m_rd = q.pop_front();
        m_have_rd = 1;
      end
      if (accepted) begin
        q.push_back(bm_data);
        if (m_ptr == m_ea) m_go = 0;
        else m_ptr = m_ptr + 1;
        m_blk = (m_blk == m_blen) ? '0 : m_blk + 1;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_sa = reg_wdata[31:2];
          2'd1: m_ea = reg_wdata[31:2];
          2'd2: begin
            m_type = reg_wdata[23:22]; m_dly = reg_wdata[21:20];
            m_mode = reg_wdata[17]; m_go = reg_wdata[16];
            m_blen = reg_wdata[15:2];
            if (reg_wdata[16] && !old_go) begin
              m_ptr = m_sa; m_blk = '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 bm_req", 32'(bm_req), 32'(m_req()));
      chk("R5 bm_addr", bm_addr, {m_ptr, 2'b00});
      chk("R7 blk_irq", 32'(blk_irq), 32'(m_irq));
      chk("R9 fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
      chk("R2 reg_rdata", reg_rdata, m_rdata);
      chk("R10 dram_type", 32'(dram_type), 32'(m_type));
      chk("R10 mux_delay", 32'(mux_delay), 32'(m_dly));
      if (m_have_rd) chk("R9 fifo_rd_data", fifo_rd_data, m_rd);
    end
  end

  // background bus master and consumer
  always @(negedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    bm_data <= {lf, ~lf ^ 16'h5A5A};
    case (drv_mode)
      1: begin bm_ack <= (lf[1:0] != 2'b00); fifo_rd_en <= (lf[3:2] == 2'b00); end
      2: begin bm_ack <= lf[0]; fifo_rd_en <= lf[2] | lf[3]; end
      3: begin bm_ack <= lf[4]; fifo_rd_en <= 1'b1; end
      default: begin bm_ack <= 1'b0; fifo_rd_en <= 1'b0; end
    endcase
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      summary();
    end
  end

  task automatic idle(int n, logic [1:0] sel);
    reg_addr = sel;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_stop(int limit);
    for (int i = 0; i < limit && m_go; i++) @(negedge clk);
  endtask

  localparam logic [31:0] MODE2 = 32'h0002_0000;
  localparam logic [31:0] GO    = 32'h0001_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ctrl", reg_rdata, 32'h0010_0003);
    chk("R1 req", 32'(bm_req), 0);
    chk("R1 irq", 32'(blk_irq), 0);
    chk("R1 empty", 32'(fifo_empty), 1);
    chk("R1 type", 32'(dram_type), 0);
    chk("R1 dly", 32'(mux_delay), 1);
    idle(2, 2'd3);
    chk("R2 idx3", reg_rdata, 0);

    // R2: address registers drop bits 1:0
    wr(2'd0, 32'h0000_1003);
    wr(2'd1, 32'h0000_1000 + 19 * 4 + 2);
    idle(2, 2'd0);
    chk("R2 first", reg_rdata, 32'h0000_1000);
    idle(2, 2'd1);
    chk("R2 last", reg_rdata, 32'h0000_104C);

    // R4: go without DMA mode, bus master acknowledging
    wr(2'd2, GO | 32'h0010_0000);
    drv_mode = 1;
    idle(20, 2'd2);
    chk("R4 no req mode1", 32'(bm_req), 0);
    chk("R4 fifo untouched", 32'(fifo_empty), 1);
    drv_mode = 0;
    wr(2'd2, 32'h0010_0000);

    // R5 R6 R7 R8: full run, FIFO runs full, block of 4 dwords
    wr(2'd2, (2 << 22) | (3 << 20) | MODE2 | GO | (3 << 2));
    idle(1, 2'd2);
    chk("R10 type", 32'(dram_type), 2);
    drv_mode = 1;
    wait_stop(2000);
    idle(3, 2'd2);
    chk("R8 stopped", 32'(bm_req), 0);
    chk("R8 parked", bm_addr, 32'h0000_104C);
    drv_mode = 3;
    idle(30, 2'd0);
    chk("R9 drained", 32'(fifo_empty), 1);

    // R11 R5: one-dword blocks, software stop then restart
    wr(2'd0, 32'h0000_2000);
    wr(2'd1, 32'h0000_2000 + 7 * 4);
    drv_mode = 2;
    wr(2'd2, MODE2 | GO);
    idle(4, 2'd2);
    wr(2'd2, MODE2);
    chk("R11 req dropped", 32'(bm_req), 0);
    idle(5, 2'd1);
    wr(2'd2, MODE2 | GO | (1 << 20));
    chk("R5 reload", bm_addr, 32'h0000_2000);
    wait_stop(2000);
    drv_mode = 3;
    idle(30, 2'd2);
    chk("R8 done", 32'(bm_req), 0);
    drv_mode = 0;
    idle(4, 2'd2);
    summary();
  end

endmodule